// File: doc/BRIEF.md
# Downstream configuration address translator

This block sits in the downstream path of a bridge between two PCI buses. Each address phase on the primary side is sampled together with its command/byte-enable nibble. The block then decides whether the phase is a hierarchical (Type 1) configuration access aimed at a device sitting directly on the secondary bus. When it is, the block claims the cycle and rewrites the address into local (Type 0) form for the secondary bus.

The rewrite has four parts:

- The type bits are cleared.
- The device-number field is cleared.
- A one-hot select pattern is placed in the upper address half. Each bit of that pattern can drive one device's configuration-select line.
- The function and register fields pass through untouched.

The secondary bus number lives in a small register inside the block, loaded through a write strobe. It starts unprogrammed after reset, and until it is loaded nothing is claimed.

Address phases tagged as coming from the secondary side never reach the outputs. This keeps conversion strictly downstream.

Top module: `cfg_t1_xlate`

## Requirements
- R1: A primary address phase is claimed only when addr_i[1:0] equals 2'b01.
- R2: A phase is claimed only when addr_i[23:16] equals the bus number. The bus number is loaded from bus_num_i on a clock edge with bus_num_we_i high, and a phase can be claimed only if a load has happened since reset.
- R3: A phase is claimed only when cbe_i is 4'b1010 (configuration read) or 4'b1011 (configuration write). cfg_write_o takes the value of cbe_i[0] from the sampled phase.
- R4: For every sampled primary phase, fwd_addr_o[1:0] and fwd_addr_o[15:11] are zero, and fwd_addr_o[10:2] equals addr_i[10:2].
- R5: For a device number N = addr_i[15:11], fwd_addr_o[31:16] has only bit 16+N set when N is 0 to 15. It is all zero when N is 16 to 31.
- R6: An address phase with src_sec_i high is ignored: claim_o, cfg_write_o and fwd_addr_o keep their previous values.
- R7: All outputs are registered. They update on the clock edge where addr_valid_i is high with src_sec_i low, and hold in every other cycle.
- R8: While rst_ni is low, claim_o, cfg_write_o and fwd_addr_o are zero and the bus number returns to the unprogrammed state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_valid_i | input | 1 | Address-phase strobe |
| src_sec_i | input | 1 | Phase originates on the secondary side |
| addr_i | input | 32 | Address word of the phase |
| cbe_i | input | 4 | Command nibble of the phase |
| bus_num_we_i | input | 1 | Load strobe for the secondary bus number |
| bus_num_i | input | 8 | Secondary bus number to load |
| claim_o | output | 1 | Phase claimed for downstream Type 0 forwarding |
| cfg_write_o | output | 1 | Direction of the sampled phase, 1 = write |
| fwd_addr_o | output | 32 | Rewritten secondary address |

## Verification
The main sweep programs a bus number. It then crosses all 32 device numbers with all 16 command codes and all four type-bit values. That separates the three claim terms from one another, and it checks the one-hot select pattern, including the empty pattern for device numbers 16 and up.

Targeted phases follow:
- Bus-number mismatches, and an all-zero bus number both before and after it is programmed, show that the programmed flag matters and not only the compare.
- Secondary-side phases and idle cycles that follow a claimed phase show that the outputs hold.
- A mid-run reset shows that the outputs clear and the bus number drops back to unprogrammed.

// File: rtl/cfg_xlate_pkg.sv
package cfg_xlate_pkg;
  localparam int unsigned ADDR_W    = 32;
  localparam int unsigned BUS_W     = 8;
  localparam int unsigned BUS_LSB   = 16;
  localparam int unsigned DEV_W     = 5;
  localparam int unsigned DEV_LSB   = 11;
  localparam int unsigned IDSEL_LSB = 16;
  localparam int unsigned IDSEL_W   = 16;

  localparam logic [1:0] TYPE1_CODE  = 2'b01;
  localparam logic [3:0] CMD_CFG_RD  = 4'b1010;
  localparam logic [3:0] CMD_CFG_WR  = 4'b1011;
  // rd and wr differ only in bit 0
  localparam logic [2:0] CMD_CFG_HI  = CMD_CFG_RD[3:1];
endpackage

// File: rtl/cfg_busnum_reg.sv
module cfg_busnum_reg #(
  parameter int unsigned BUS_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [BUS_W-1:0] bus_num_i,
  output logic [BUS_W-1:0] bus_num_o,
  output logic             prog_o
);
  logic [BUS_W-1:0] bus_q;
  logic             prog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_q  <= '0;
      prog_q <= 1'b0;
    end else if (we_i) begin
      bus_q  <= bus_num_i;
      prog_q <= 1'b1;
    end
  end

  assign bus_num_o = bus_q;
  assign prog_o    = prog_q;

  AST_PROG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_o |=> prog_o); // R2
endmodule

// File: rtl/cfg_claim_dec.sv
module cfg_claim_dec
  import cfg_xlate_pkg::*;
#(
  parameter int unsigned BUS_W = 8
) (
  input  logic [1:0]       type_i,
  input  logic [BUS_W-1:0] addr_bus_i,
  input  logic [BUS_W-1:0] sec_bus_i,
  input  logic             prog_i,
  input  logic [3:0]       cbe_i,
  output logic             claim_o
);
  logic is_type1;
  logic bus_hit;
  logic is_cfg;

  assign is_type1 = (type_i == TYPE1_CODE);
  assign bus_hit  = prog_i && (addr_bus_i == sec_bus_i);
  assign is_cfg   = (cbe_i[3:1] == CMD_CFG_HI);
  assign claim_o  = is_type1 && bus_hit && is_cfg;
endmodule

// File: rtl/cfg_idsel_dec.sv
module cfg_idsel_dec #(
  parameter int unsigned DEV_W   = 5,
  parameter int unsigned IDSEL_W = 16
) (
  input  logic [DEV_W-1:0]   dev_i,
  output logic [IDSEL_W-1:0] idsel_o
);
  // device numbers at or above IDSEL_W select nothing
  for (genvar g = 0; g < IDSEL_W; g++) begin : g_sel
    assign idsel_o[g] = (dev_i == DEV_W'(g));
  end
endmodule

// File: rtl/cfg_addr_rewrite.sv
module cfg_addr_rewrite #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DEV_LSB   = 11,
  parameter int unsigned DEV_W     = 5,
  parameter int unsigned IDSEL_LSB = 16,
  localparam int unsigned IDSEL_W  = ADDR_W - IDSEL_LSB
) (
  input  logic [IDSEL_LSB-1:0] addr_lo_i,
  input  logic [IDSEL_W-1:0]   idsel_i,
  output logic [ADDR_W-1:0]    fwd_o
);
  logic [IDSEL_LSB-1:0] lo;

  always_comb begin
    lo = addr_lo_i;
    lo[DEV_LSB+DEV_W-1:DEV_LSB] = '0;
    lo[1:0] = 2'b00;
  end

  assign fwd_o = {idsel_i, lo};
endmodule

// File: rtl/cfg_t1_xlate.sv
module cfg_t1_xlate
  import cfg_xlate_pkg::*;
#(
  parameter int unsigned AW        = ADDR_W,
  parameter int unsigned BW        = BUS_W,
  parameter int unsigned BLSB      = BUS_LSB,
  parameter int unsigned DW        = DEV_W,
  parameter int unsigned DLSB      = DEV_LSB,
  parameter int unsigned SLSB      = IDSEL_LSB,
  localparam int unsigned SW       = AW - SLSB,
  localparam int unsigned BUS_MSB  = BLSB + BW - 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          addr_valid_i,
  input  logic          src_sec_i,
  input  logic [AW-1:0] addr_i,
  input  logic [3:0]    cbe_i,
  input  logic          bus_num_we_i,
  input  logic [BW-1:0] bus_num_i,
  output logic          claim_o,
  output logic          cfg_write_o,
  output logic [AW-1:0] fwd_addr_o
);
  logic [BW-1:0] sec_bus;
  logic          bus_prog;
  logic          claim_d;
  logic [SW-1:0] idsel;
  logic [AW-1:0] fwd_d;
  logic          sample;
  logic          unused_addr_hi;

  logic          claim_q;
  logic          write_q;
  logic [AW-1:0] fwd_q;

  assign unused_addr_hi = ^addr_i[AW-1:BUS_MSB+1];

  cfg_busnum_reg #(.BUS_W(BW)) i_busnum (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (bus_num_we_i),
    .bus_num_i (bus_num_i),
    .bus_num_o (sec_bus),
    .prog_o    (bus_prog)
  );

  cfg_claim_dec #(.BUS_W(BW)) i_claim (
    .type_i     (addr_i[1:0]),
    .addr_bus_i (addr_i[BUS_MSB:BLSB]),
    .sec_bus_i  (sec_bus),
    .prog_i     (bus_prog),
    .cbe_i      (cbe_i),
    .claim_o    (claim_d)
  );

  cfg_idsel_dec #(.DEV_W(DW), .IDSEL_W(SW)) i_idsel (
    .dev_i   (addr_i[DLSB+DW-1:DLSB]),
    .idsel_o (idsel)
  );

  cfg_addr_rewrite #(
    .ADDR_W(AW), .DEV_LSB(DLSB), .DEV_W(DW), .IDSEL_LSB(SLSB)
  ) i_rewrite (
    .addr_lo_i (addr_i[SLSB-1:0]),
    .idsel_i   (idsel),
    .fwd_o     (fwd_d)
  );

  // secondary-side phases never load: no upstream conversion
  assign sample = addr_valid_i && !src_sec_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      claim_q <= 1'b0;
      write_q <= 1'b0;
      fwd_q   <= '0;
    end else if (sample) begin
      claim_q <= claim_d;
      write_q <= cbe_i[0];
      fwd_q   <= fwd_d;
    end
  end

  assign claim_o     = claim_q;
  assign cfg_write_o = write_q;
  assign fwd_addr_o  = fwd_q;

  AST_TYPE1_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample && addr_i[1:0] != TYPE1_CODE) |=> !claim_o); // R1
  AST_UNPROG_NO_CLAIM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample && !bus_prog) |=> !claim_o); // R2
  AST_CFG_CMD_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample && cbe_i != CMD_CFG_RD && cbe_i != CMD_CFG_WR) |=> !claim_o); // R3
  AST_FWD_FIELDS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    claim_o |-> (fwd_addr_o[1:0] == 2'b00 && fwd_addr_o[DLSB+DW-1:DLSB] == '0)); // R4
  AST_IDSEL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(fwd_addr_o[AW-1:SLSB])); // R5
  AST_SEC_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_valid_i && src_sec_i) |=>
      ($stable(claim_o) && $stable(cfg_write_o) && $stable(fwd_addr_o))); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_valid_i |=>
      ($stable(claim_o) && $stable(cfg_write_o) && $stable(fwd_addr_o))); // R7
endmodule

// File: tb/test_cfg_t1_xlate.sv
module test_cfg_t1_xlate;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        addr_valid = 1'b0;
  logic        src_sec = 1'b0;
  logic [31:0] addr = '0;
  logic [3:0]  cbe = '0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_num = '0;
  logic        claim;
  logic        cfg_write;
  logic [31:0] fwd_addr;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_t1_xlate i_cfg_t1_xlate (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .addr_valid_i (addr_valid),
    .src_sec_i    (src_sec),
    .addr_i       (addr),
    .cbe_i        (cbe),
    .bus_num_we_i (bus_we),
    .bus_num_i    (bus_num),
    .claim_o      (claim),
    .cfg_write_o  (cfg_write),
    .fwd_addr_o   (fwd_addr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp_v);
    end
  endtask

  function automatic logic [31:0] exp_fwd(input logic [31:0] a);
    logic [15:0] sel;
    sel = (a[15:11] < 5'd16) ? (16'h1 << a[15:11]) : 16'h0;
    return {sel, 5'b0, a[10:2], 2'b00};
  endfunction

  // drive one address phase, return at the next falling edge
  task automatic phase(input logic [31:0] a, input logic [3:0] c, input logic sec);
    addr = a; cbe = c; src_sec = sec; addr_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    addr_valid = 1'b0; src_sec = 1'b0;
  endtask

  task automatic load_bus(input logic [7:0] b);
    bus_num = b; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > WATCHDOG && !done) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, WATCHDOG);
        finish_run();
      end
    end
  end

  initial begin
    logic [31:0] a;
    logic [31:0] held_addr;
    logic        held_claim;
    logic        held_wr;

    repeat (3) @(negedge clk);
    chk("R8 reset claim", 32'(claim), 32'd0);
    chk("R8 reset fwd", fwd_addr, 32'd0);
    chk("R8 reset write", 32'(cfg_write), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // bus field 0 matches reset value but nothing programmed yet
    phase(32'h0000_0801, 4'b1010, 1'b0);
    chk("R2 unprogrammed no claim", 32'(claim), 32'd0);
    chk("R5 fwd before program", fwd_addr, exp_fwd(32'h0000_0801));

    load_bus(8'h5A);

    for (int dev = 0; dev < 32; dev++) begin
      for (int cmd = 0; cmd < 16; cmd++) begin
        for (int low = 0; low < 4; low++) begin
          a = {8'hA5, 8'h5A, 5'(dev), 3'(dev ^ cmd), 6'((dev * 7 + cmd) & 63), 2'(low)};
          phase(a, 4'(cmd), 1'b0);
          chk("R1 R3 sweep claim", 32'(claim),
              32'((low == 1) && (cmd == 10 || cmd == 11)));
          chk("R4 R5 sweep fwd", fwd_addr, exp_fwd(a));
          chk("R3 sweep write", 32'(cfg_write), 32'(cmd & 1));
        end
      end
    end

    // bus mismatch on either side of the programmed value
    phase({8'h00, 8'h5B, 5'd3, 3'd1, 6'd2, 2'b01}, 4'b1010, 1'b0);
    chk("R2 bus above no claim", 32'(claim), 32'd0);
    phase({8'h00, 8'h59, 5'd3, 3'd1, 6'd2, 2'b01}, 4'b1011, 1'b0);
    chk("R2 bus below no claim", 32'(claim), 32'd0);

    // claimed write to device 15, then secondary-side phase must be ignored
    a = {8'h00, 8'h5A, 5'd15, 3'd7, 6'd63, 2'b01};
    phase(a, 4'b1011, 1'b0);
    chk("R5 dev15 claim", 32'(claim), 32'd1);
    chk("R5 dev15 fwd", fwd_addr, 32'h8000_07FC);
    held_addr = fwd_addr; held_claim = claim; held_wr = cfg_write;
    phase({8'h00, 8'h5A, 5'd2, 3'd0, 6'd0, 2'b00}, 4'b1010, 1'b1);
    chk("R6 sec fwd held", fwd_addr, held_addr);
    chk("R6 sec claim held", 32'(claim), 32'(held_claim));
    chk("R6 sec write held", 32'(cfg_write), 32'(held_wr));
    phase({8'h00, 8'h5A, 5'd4, 3'd0, 6'd0, 2'b01}, 4'b1010, 1'b1);
    chk("R6 sec type1 fwd held", fwd_addr, held_addr);

    // idle with changing inputs
    addr = 32'hFFFF_FFFF; cbe = 4'b0000;
    repeat (5) @(negedge clk);
    chk("R7 idle fwd held", fwd_addr, held_addr);
    chk("R7 idle claim held", 32'(claim), 32'd1);
    chk("R7 idle write held", 32'(cfg_write), 32'd1);

    // bus number zero once programmed
    load_bus(8'h00);
    a = {8'h12, 8'h00, 5'd0, 3'd2, 6'd5, 2'b01};
    phase(a, 4'b1010, 1'b0);
    chk("R2 bus zero programmed claim", 32'(claim), 32'd1);
    chk("R5 dev0 fwd", fwd_addr, 32'h0001_0214);
    chk("R3 read dir", 32'(cfg_write), 32'd0);

    // reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    chk("R8 mid reset claim", 32'(claim), 32'd0);
    chk("R8 mid reset fwd", fwd_addr, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    phase(a, 4'b1010, 1'b0);
    chk("R8 bus unprogrammed after reset", 32'(claim), 32'd0);

    finish_run();
  end
endmodule